// File: doc/BRIEF.md
# Hash Round-Function Accumulate Unit

This block evaluates one of twelve 32-bit boolean or rotate-and-XOR functions that appear in the round steps of MD5, SHA-1 and SHA-256. It adds the result, modulo 2^32, into an internal 32-bit accumulator. A 4-bit function code picks the function. Each function reads fixed words of a seven-word operand bank, or a separate message-schedule word.

A round controller drives the operand words and the code, then pulses `start`. One clock later the accumulator holds the new sum and `done` pulses. The controller can overwrite the accumulator directly through a load port, for example to seed it with a working variable before a chain of additions. Message expansion, round constants and the sequencing of rounds are left to the surrounding logic.

Top module: `hash_round_unit`

## Requirements
- R1: While `rst_n` is low, `acc_out` is 0, and `done` and `bad_code` are 0.
- R2: With bank word i at `opnd_bank[32*i +: 32]` and x=word1, y=word2, z=word3, the codes select these functions:
  - code 0: (x&y)|(~x&z)
  - code 1: (x&z)|(y&~z)
  - code 2: x^y^z, which also serves as the SHA-1 parity function
  - code 3: y^(x|~z)
- R3: With a=word1, b=word2, c=word3, code 4 selects (a&b)^(~a&c) and code 5 selects (a&b)^(a&c)^(b&c).
- R4: Code 6 selects (word4&word5)^(~word4&word6). Code 7 selects the majority of word0, word1 and word2.
- R5: Code 8 selects rotr2^rotr13^rotr22 of word0. Code 9 selects rotr6^rotr11^rotr25 of word4. Both rotations are to the right.
- R6: With s=`sched_word`, code 10 selects rotr7(s)^rotr18(s)^shr3(s) and code 11 selects rotr17(s)^rotr19(s)^shr10(s).
- R7: A `start` sampled at a rising edge without `acc_load` replaces the accumulator with (accumulator + function result) mod 2^32 at that same edge. `done` is high for the following cycle only, unless `start` is sampled again.
- R8: For codes 12 to 15, a `start` leaves the accumulator unchanged. `bad_code` and `done` are both high for the following cycle.
- R9: `acc_load` sampled at an edge writes `acc_wdata` into the accumulator. A `start` sampled in the same cycle is ignored, so `done` stays low.
- R10: With neither `start` nor `acc_load`, the accumulator holds its value whatever the operands and code do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one accumulate step |
| func_sel | input | 4 | Function code, 0 to 15 |
| opnd_bank | input | 224 | Operand words 0 to 6, word i at bits 32*i+31:32*i |
| sched_word | input | 32 | Message-schedule word for codes 10 and 11 |
| acc_load | input | 1 | Write `acc_wdata` into the accumulator |
| acc_wdata | input | 32 | Value for an accumulator load |
| acc_out | output | 32 | Accumulator contents |
| done | output | 1 | One-cycle pulse after an accepted `start` |
| bad_code | output | 1 | Pulse with `done` when the code was 12 to 15 |

## Verification
The accumulator is the only state that carries over from one step to the next. A wrong function term or a corrupted sum shows on `acc_out` at the negative edge that follows the `start` edge, and it spoils every later sum in the chain. A faulty `done` or `bad_code` flop shows within that same cycle. A wrong load priority or a missing hold shows as a single `acc_out` mismatch one cycle after the stimulus.

// File: rtl/hru_pkg.sv
package hru_pkg;
  localparam int WORD_W     = 32;
  localparam int BANK_WORDS = 7;
  localparam int CODE_W     = 4;
  localparam int BANK_W     = WORD_W * BANK_WORDS;

  typedef logic [WORD_W-1:0] word_t;

  // rotation and shift amounts of the four SHA-256 sigma functions
  localparam int BS0_A = 2,  BS0_B = 13, BS0_C = 22;
  localparam int BS1_A = 6,  BS1_B = 11, BS1_C = 25;
  localparam int SS0_A = 7,  SS0_B = 18, SS0_S = 3;
  localparam int SS1_A = 17, SS1_B = 19, SS1_S = 10;

  // codes at or above this value are not defined
  localparam logic [CODE_W-1:0] FIRST_BAD_CODE = 4'hC;

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t choose(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (~a & c);
  endfunction

  function automatic word_t majority(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

  function automatic word_t add_wrap(input word_t a, input word_t b);
    return a + b;
  endfunction
endpackage

// File: rtl/hru_bool_sel.sv
module hru_bool_sel
  import hru_pkg::*;
(
  input  logic [2:0]        sel,
  input  logic [BANK_W-1:0] bank,
  output word_t             result
);
  word_t w [BANK_WORDS];

  for (genvar i = 0; i < BANK_WORDS; i++) begin : g_unpack
    assign w[i] = bank[i*WORD_W +: WORD_W];
  end

  always_comb begin
    unique case (sel)
      3'd0: result = (w[1] & w[2]) | (~w[1] & w[3]);
      3'd1: result = (w[1] & w[3]) | (w[2] & ~w[3]);
      3'd2: result = w[1] ^ w[2] ^ w[3];
      3'd3: result = w[2] ^ (w[1] | ~w[3]);
      3'd4: result = choose(w[1], w[2], w[3]);
      3'd5: result = majority(w[1], w[2], w[3]);
      3'd6: result = choose(w[4], w[5], w[6]);
      default: result = majority(w[0], w[1], w[2]);
    endcase
  end
endmodule

// File: rtl/hru_rot_sel.sv
module hru_rot_sel
  import hru_pkg::*;
(
  input  logic [1:0] sel,
  input  word_t      w0,
  input  word_t      w4,
  input  word_t      sched,
  output word_t      result
);
  word_t big0, big1, small0, small1;

  assign big0   = rotr(w0, BS0_A) ^ rotr(w0, BS0_B) ^ rotr(w0, BS0_C);
  assign big1   = rotr(w4, BS1_A) ^ rotr(w4, BS1_B) ^ rotr(w4, BS1_C);
  assign small0 = rotr(sched, SS0_A) ^ rotr(sched, SS0_B) ^ (sched >> SS0_S);
  assign small1 = rotr(sched, SS1_A) ^ rotr(sched, SS1_B) ^ (sched >> SS1_S);

  always_comb begin
    unique case (sel)
      2'd0: result = big0;
      2'd1: result = big1;
      2'd2: result = small0;
      default: result = small1;
    endcase
  end
endmodule

// File: rtl/hru_acc.sv
module hru_acc
  import hru_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  load,
  input  word_t wdata,
  input  word_t fn_val,
  input  logic  fn_legal,
  output word_t acc_q,
  output logic  done_q,
  output logic  bad_q
);
  logic step_ok, step_bad;
  assign step_ok  = start && !load && fn_legal;
  assign step_bad = start && !load && !fn_legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      if (load)         acc_q <= wdata;
      else if (step_ok) acc_q <= add_wrap(acc_q, fn_val);
      done_q <= step_ok || step_bad;
      bad_q  <= step_bad;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !load) |=> $stable(acc_q));
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_q == $past(wdata)) && !done_q);
  p_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !load && fn_legal) |=> (acc_q == add_wrap($past(acc_q), $past(fn_val))) && done_q && !bad_q);
  p_bad_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !load && !fn_legal) |=> bad_q && done_q && $stable(acc_q));
  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done_q);
endmodule

// File: rtl/hash_round_unit.sv
module hash_round_unit
  import hru_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] func_sel,
  input  logic [BANK_W-1:0] opnd_bank,
  input  logic [WORD_W-1:0] sched_word,
  input  logic              acc_load,
  input  logic [WORD_W-1:0] acc_wdata,
  output logic [WORD_W-1:0] acc_out,
  output logic              done,
  output logic              bad_code
);
  word_t bool_res, rot_res, fn_val;
  logic  fn_legal;

  hru_bool_sel u_bool (
    .sel    (func_sel[2:0]),
    .bank   (opnd_bank),
    .result (bool_res)
  );

  hru_rot_sel u_rot (
    .sel    (func_sel[1:0]),
    .w0     (opnd_bank[0*WORD_W +: WORD_W]),
    .w4     (opnd_bank[4*WORD_W +: WORD_W]),
    .sched  (sched_word),
    .result (rot_res)
  );

  assign fn_legal = (func_sel < FIRST_BAD_CODE);
  assign fn_val   = func_sel[3] ? rot_res : bool_res;

  hru_acc u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load     (acc_load),
    .wdata    (acc_wdata),
    .fn_val   (fn_val),
    .fn_legal (fn_legal),
    .acc_q    (acc_out),
    .done_q   (done),
    .bad_q    (bad_code)
  );

  p_bad_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |-> done);
endmodule

// File: tb/sim_hash_round_unit.sv
module sim_hash_round_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   func_sel = '0;
  logic [223:0] opnd_bank = '0;
  logic [31:0]  sched_word = '0;
  logic         acc_load = 1'b0;
  logic [31:0]  acc_wdata = '0;
  logic [31:0]  acc_out;
  logic         done, bad_code;

  int total = 0;
  int bad = 0;
  logic [31:0] model;

  always #10 clk = ~clk;

  hash_round_unit u0 (.*);

  function automatic logic [31:0] wd(input int i);
    return opnd_bank[i*32 +: 32];
  endfunction

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d = {x, x} >> n;
    return d[31:0];
  endfunction

  function automatic logic [31:0] bitmux(input logic [31:0] s, input logic [31:0] t, input logic [31:0] f);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[b] = s[b] ? t[b] : f[b];
    return r;
  endfunction

  function automatic logic [31:0] vote(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[k] = (32'(a[k]) + 32'(b[k]) + 32'(c[k])) >= 2;
    return r;
  endfunction

  function automatic logic [31:0] ref_fn(input logic [3:0] c);
    logic [31:0] s = sched_word;
    case (c)
      4'd0: return bitmux(wd(1), wd(2), wd(3));
      4'd1: return bitmux(wd(3), wd(1), wd(2));
      4'd2: return wd(1) ^ wd(2) ^ wd(3);
      4'd3: return wd(2) ^ (wd(1) | ~wd(3));
      4'd4: return bitmux(wd(1), wd(2), wd(3));
      4'd5: return vote(wd(1), wd(2), wd(3));
      4'd6: return bitmux(wd(4), wd(5), wd(6));
      4'd7: return vote(wd(0), wd(1), wd(2));
      4'd8: return rr(wd(0), 2) ^ rr(wd(0), 13) ^ rr(wd(0), 22);
      4'd9: return rr(wd(4), 6) ^ rr(wd(4), 11) ^ rr(wd(4), 25);
      4'd10: return rr(s, 7) ^ rr(s, 18) ^ {3'b0, s[31:3]};
      4'd11: return rr(s, 17) ^ rr(s, 19) ^ {10'b0, s[31:10]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c <= 3) return "R2";
    if (c <= 5) return "R3";
    if (c <= 7) return "R4";
    if (c <= 9) return "R5";
    if (c <= 11) return "R6";
    return "R8";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rand_bank();
    for (int i = 0; i < 7; i++) opnd_bank[i*32 +: 32] = $urandom;
    sched_word = $urandom;
  endtask

  task automatic load_acc(input logic [31:0] v);
    @(negedge clk);
    acc_load = 1'b1; acc_wdata = v;
    @(negedge clk);
    acc_load = 1'b0;
    model = v;
    chk(acc_out == v, "R9", acc_out, v);
  endtask

  task automatic do_op(input logic [3:0] c, input bit check_pulse);
    logic [31:0] exp;
    bit illegal = (c >= 4'hC);
    exp = illegal ? model : model + ref_fn(c);
    @(negedge clk);
    func_sel = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(acc_out == exp, req_of(c), acc_out, exp);
    chk(done == 1'b1, "R7", {31'b0, done}, 32'd1);
    chk(bad_code == illegal, "R8", {31'b0, bad_code}, {31'b0, illegal});
    model = exp;
    if (check_pulse) begin
      @(negedge clk);
      chk(done == 1'b0 && bad_code == 1'b0, "R7", {30'b0, done, bad_code}, 32'd0);
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rand_bank();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(acc_out == 0, "R1", acc_out, 0);
    chk(done == 0 && bad_code == 0, "R1", {30'b0, done, bad_code}, 0);
    rst_n = 1'b1;
    model = 0;

    // directed: every code once, with pulse check
    for (int c = 0; c < 16; c++) begin
      rand_bank();
      do_op(4'(c), 1'b1);
    end

    // R7 wrap-around: 0xFFFFFFF0 + 0x20 -> 0x10 (code 2)
    load_acc(32'hFFFF_FFF0);
    opnd_bank = '0; opnd_bank[1*32 +: 32] = 32'h20;
    do_op(4'd2, 1'b0);
    chk(acc_out == 32'h10, "R7", acc_out, 32'h10);

    // R9: load and start together, load wins, no done
    rand_bank();
    @(negedge clk);
    acc_load = 1'b1; acc_wdata = 32'hA5A5_0F0F; start = 1'b1; func_sel = 4'd0;
    @(negedge clk);
    acc_load = 1'b0; start = 1'b0;
    chk(acc_out == 32'hA5A5_0F0F, "R9", acc_out, 32'hA5A5_0F0F);
    chk(done == 1'b0, "R9", {31'b0, done}, 0);
    model = 32'hA5A5_0F0F;

    // R10: idle cycles with changing operands and code
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rand_bank(); func_sel = 4'($urandom);
      @(negedge clk);
      chk(acc_out == model, "R10", acc_out, model);
      chk(done == 1'b0, "R10", {31'b0, done}, 0);
    end

    // R8: all undefined codes keep the accumulator
    for (int c = 12; c < 16; c++) do_op(4'(c), 1'b0);

    // random back-to-back steps across all codes
    for (int n = 0; n < 300; n++) begin
      rand_bank();
      if (($urandom % 25) == 0) load_acc($urandom);
      do_op(4'($urandom), (($urandom % 4) == 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule